// File: doc/BRIEF.md
# Timer Interrupt Routing Selector

This block sits between a bank of timer channels and the interrupt controllers of a system. Each timer raises an interrupt line; the selector decides where that line lands. It can land on one of 32 inputs of an I/O interrupt controller, on one of two fixed legacy lines, or on a message-delivery path that issues a single-cycle request strobe to a separate message sender. Inputs sharing a destination are ORed, so several timers may share one controller input.

Software-visible routing state is one 5-bit route per timer, written through a single write port. A write is accepted only if the timer's 32-bit capability mask has the bit for the requested input set. Otherwise the stored route is kept, and a readback then shows a value other than the one written. A global legacy-replacement enable takes timers 0 and 1 away from their stored routes and pins them to fixed outputs. A per-timer message enable, honoured only when that timer's message capability is set, moves its interrupt to the strobe path.

All interrupt outputs are registered. Each one reflects the timer levels and the configuration seen at the previous rising clock edge.

Top module: `timer_irq_router`

## Requirements
- R1: After synchronous reset every output is low: all 32 controller lines, both legacy lines and all message strobes. Every stored route reads back as 0.
- R2: With legacy replacement on, timer 0 drives legacy line 0 and controller input 2, one cycle after its interrupt is seen. Its stored route and its message enable are ignored.
- R3: With legacy replacement on, timer 1 drives legacy line 8 and controller input 8, one cycle after its interrupt is seen. Its stored route and its message enable are ignored.
- R4: A timer that is not pinned by legacy replacement and not on the message path drives the controller input numbered by its stored 5-bit route, one cycle later. With legacy replacement off, both legacy lines stay low.
- R5: A route write sets the selected timer's stored route to the written value when bit <value> of that timer's capability mask is 1. Readback shows the new value in the cycle after the write edge.
- R6: A route write whose capability bit is 0 leaves the stored route unchanged, and routing continues to use the old value.
- R7: Timers that resolve to the same controller input are ORed onto that input.
- R8: A timer whose message enable and message capability are both 1 (and which is not pinned by legacy replacement) drives no controller input. It produces a message strobe that is high for exactly one cycle, one cycle after the edge at which its interrupt is first seen high.
- R9: A message enable whose message capability is 0 has no effect: the timer routes by its stored route and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tmr_irq_i | input | NUM_TIMERS | Interrupt level of each timer |
| legacy_en_i | input | 1 | Legacy replacement enable |
| route_wr_i | input | 1 | Route write strobe |
| route_wr_sel_i | input | SEL_W | Timer selected for the route write |
| route_wr_val_i | input | 5 | Requested controller input number |
| route_cap_i | input | NUM_TIMERS*32 | Capability masks, timer t in bits [32t+31:32t] |
| route_rd_sel_i | input | SEL_W | Timer selected for route readback |
| route_rd_o | output | 5 | Stored route of the selected timer |
| msg_en_i | input | NUM_TIMERS | Per-timer message-delivery enable |
| msg_cap_i | input | NUM_TIMERS | Per-timer message-delivery capability |
| ioc_line_o | output | 32 | I/O interrupt controller inputs |
| leg_irq0_o | output | 1 | Legacy line 0 |
| leg_irq8_o | output | 1 | Legacy line 8 |
| msg_req_o | output | NUM_TIMERS | Per-timer message request strobes |

## Verification
A corrupted stored route shows at the readback port in the cycle after the write. It shows on the controller lines one cycle after the timer's interrupt is next raised, as a set bit at the wrong position. A stale edge-detect register shows as a missing or doubled strobe in the very cycle after an interrupt rises. A wrong destination choice shows as a legacy line, controller bit or strobe that disagrees with the mode inputs one cycle after any interrupt. Because every path is a single register deep, no fault stays hidden longer than one cycle past its stimulus.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam int unsigned IOC_LINES   = 32;
    localparam int unsigned ROUTE_W     = $clog2(IOC_LINES);
    localparam int unsigned LEG_LINE_T0 = 2;
    localparam int unsigned LEG_LINE_T1 = 8;

    // where a single timer's interrupt ends up
    typedef enum logic [1:0] {
        DEST_ROUTED  = 2'd0,
        DEST_LEGACY  = 2'd1,
        DEST_MESSAGE = 2'd2
    } dest_kind_e;

    typedef struct packed {
        dest_kind_e           kind;
        logic [ROUTE_W-1:0]   line;
    } dest_t;

    function automatic int unsigned sel_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Priority: legacy pinning of timers 0/1, then message path, then route.
    function automatic dest_t pick_dest(int unsigned idx, logic legacy,
                                        logic msg_ok, logic [ROUTE_W-1:0] stored);
        dest_t d;
        d.kind = DEST_ROUTED;
        d.line = stored;
        if (legacy && idx == 0) begin
            d.kind = DEST_LEGACY;
            d.line = ROUTE_W'(LEG_LINE_T0);
        end else if (legacy && idx == 1) begin
            d.kind = DEST_LEGACY;
            d.line = ROUTE_W'(LEG_LINE_T1);
        end else if (msg_ok) begin
            d.kind = DEST_MESSAGE;
        end
        return d;
    endfunction

endpackage

// File: rtl/trs_route_store.sv
module trs_route_store
    import trs_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 4,
    parameter int unsigned SEL_W      = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en_i,
    input  logic [SEL_W-1:0]                 wr_sel_i,
    input  logic [ROUTE_W-1:0]               wr_val_i,
    input  logic [NUM_TIMERS*IOC_LINES-1:0]  cap_i,
    input  logic [SEL_W-1:0]                 rd_sel_i,
    output logic [ROUTE_W-1:0]               rd_val_o,
    output logic [NUM_TIMERS*ROUTE_W-1:0]    routes_o
);

    logic [IOC_LINES-1:0] cap_a   [NUM_TIMERS];
    logic [ROUTE_W-1:0]   route_q [NUM_TIMERS];
    logic                 sel_ok;
    logic                 wr_ok;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_flat
        assign cap_a[g] = cap_i[g*IOC_LINES +: IOC_LINES];
        assign routes_o[g*ROUTE_W +: ROUTE_W] = route_q[g];
    end

    always_comb begin
        sel_ok = (int'(wr_sel_i) < int'(NUM_TIMERS));
        wr_ok  = 1'b0;
        if (wr_en_i && sel_ok) begin
            wr_ok = cap_a[wr_sel_i][wr_val_i];
        end
    end

    always_comb begin
        rd_val_o = '0;
        if (int'(rd_sel_i) < int'(NUM_TIMERS)) begin
            rd_val_o = route_q[rd_sel_i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < int'(NUM_TIMERS); t++) begin
                route_q[t] <= '0;
            end
        end else if (wr_ok) begin
            route_q[wr_sel_i] <= wr_val_i;
        end
    end

    assert_accept_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && sel_ok && cap_a[wr_sel_i][wr_val_i])
            |=> (route_q[$past(wr_sel_i)] == $past(wr_val_i)));

    assert_reject_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && sel_ok && !cap_a[wr_sel_i][wr_val_i])
            |=> (route_q[$past(wr_sel_i)] == $past(route_q[wr_sel_i])));

endmodule

// File: rtl/trs_dest_decode.sv
module trs_dest_decode
    import trs_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 4
) (
    input  logic [NUM_TIMERS-1:0]          irq_i,
    input  logic                           legacy_i,
    input  logic [NUM_TIMERS-1:0]          msg_ok_i,
    input  logic [NUM_TIMERS*ROUTE_W-1:0]  routes_i,
    output logic [IOC_LINES-1:0]           ioc_o,
    output logic                           leg0_o,
    output logic                           leg8_o,
    output logic [NUM_TIMERS-1:0]          msg_active_o
);

    dest_t dest_a [NUM_TIMERS];

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_dest
        assign dest_a[g] = pick_dest(g, legacy_i, msg_ok_i[g],
                                     routes_i[g*ROUTE_W +: ROUTE_W]);
        assign msg_active_o[g] = (dest_a[g].kind == DEST_MESSAGE);
    end

    // OR-combine every timer that lands on a controller input
    always_comb begin
        ioc_o  = '0;
        leg0_o = 1'b0;
        leg8_o = 1'b0;
        for (int t = 0; t < int'(NUM_TIMERS); t++) begin
            if (irq_i[t]) begin
                case (dest_a[t].kind)
                    DEST_ROUTED: ioc_o[dest_a[t].line] = 1'b1;
                    DEST_LEGACY: begin
                        ioc_o[dest_a[t].line] = 1'b1;
                        if (t == 0) leg0_o = 1'b1;
                        else        leg8_o = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/trs_msg_pulse.sv
module trs_msg_pulse #(
    parameter int unsigned NUM_TIMERS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_TIMERS-1:0] irq_i,
    input  logic [NUM_TIMERS-1:0] active_i,
    output logic [NUM_TIMERS-1:0] req_o
);

    logic [NUM_TIMERS-1:0] irq_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_prev_q <= '0;
            req_o      <= '0;
        end else begin
            irq_prev_q <= irq_i;
            req_o      <= irq_i & ~irq_prev_q & active_i;
        end
    end

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
        assert_single_R8: assert property (@(posedge clk) disable iff (rst)
            req_o[g] |=> !req_o[g]);
        assert_needs_level_R8: assert property (@(posedge clk) disable iff (rst)
            req_o[g] |-> $past(irq_i[g]));
        assert_inactive_R9: assert property (@(posedge clk) disable iff (rst)
            !active_i[g] |=> !req_o[g]);
    end

endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router
    import trs_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 4,
    parameter int unsigned SEL_W      = sel_width(NUM_TIMERS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_TIMERS-1:0]            tmr_irq_i,
    input  logic                             legacy_en_i,
    input  logic                             route_wr_i,
    input  logic [SEL_W-1:0]                 route_wr_sel_i,
    input  logic [ROUTE_W-1:0]               route_wr_val_i,
    input  logic [NUM_TIMERS*IOC_LINES-1:0]  route_cap_i,
    input  logic [SEL_W-1:0]                 route_rd_sel_i,
    output logic [ROUTE_W-1:0]               route_rd_o,
    input  logic [NUM_TIMERS-1:0]            msg_en_i,
    input  logic [NUM_TIMERS-1:0]            msg_cap_i,
    output logic [IOC_LINES-1:0]             ioc_line_o,
    output logic                             leg_irq0_o,
    output logic                             leg_irq8_o,
    output logic [NUM_TIMERS-1:0]            msg_req_o
);

    logic [NUM_TIMERS*ROUTE_W-1:0] routes;
    logic [NUM_TIMERS-1:0]         msg_ok;
    logic [NUM_TIMERS-1:0]         msg_active;
    logic [IOC_LINES-1:0]          ioc_d;
    logic                          leg0_d;
    logic                          leg8_d;

    assign msg_ok = msg_en_i & msg_cap_i;

    trs_route_store #(
        .NUM_TIMERS (NUM_TIMERS),
        .SEL_W      (SEL_W)
    ) store_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (route_wr_i),
        .wr_sel_i (route_wr_sel_i),
        .wr_val_i (route_wr_val_i),
        .cap_i    (route_cap_i),
        .rd_sel_i (route_rd_sel_i),
        .rd_val_o (route_rd_o),
        .routes_o (routes)
    );

    trs_dest_decode #(
        .NUM_TIMERS (NUM_TIMERS)
    ) decode_i (
        .irq_i        (tmr_irq_i),
        .legacy_i     (legacy_en_i),
        .msg_ok_i     (msg_ok),
        .routes_i     (routes),
        .ioc_o        (ioc_d),
        .leg0_o       (leg0_d),
        .leg8_o       (leg8_d),
        .msg_active_o (msg_active)
    );

    trs_msg_pulse #(
        .NUM_TIMERS (NUM_TIMERS)
    ) pulse_i (
        .clk      (clk),
        .rst      (rst),
        .irq_i    (tmr_irq_i),
        .active_i (msg_active),
        .req_o    (msg_req_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ioc_line_o <= '0;
            leg_irq0_o <= 1'b0;
            leg_irq8_o <= 1'b0;
        end else begin
            ioc_line_o <= ioc_d;
            leg_irq0_o <= leg0_d;
            leg_irq8_o <= leg8_d;
        end
    end

    assert_legacy_t0_R2: assert property (@(posedge clk) disable iff (rst)
        (legacy_en_i && tmr_irq_i[0]) |=> (leg_irq0_o && ioc_line_o[LEG_LINE_T0]));

    if (NUM_TIMERS > 1) begin : g_t1
        assert_legacy_t1_R3: assert property (@(posedge clk) disable iff (rst)
            (legacy_en_i && tmr_irq_i[1]) |=> (leg_irq8_o && ioc_line_o[LEG_LINE_T1]));
    end

    assert_legacy_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !legacy_en_i |=> (!leg_irq0_o && !leg_irq8_o));

    assert_idle_lines_R4: assert property (@(posedge clk) disable iff (rst)
        (tmr_irq_i == '0) |=> (ioc_line_o == '0 && !leg_irq0_o && !leg_irq8_o && msg_req_o == '0));

endmodule

// File: tb/timer_irq_router_tb_top.sv
module timer_irq_router_tb_top;

    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] tmr_irq = '0;
    logic          legacy_en = 1'b0;
    logic          route_wr = 1'b0;
    logic [1:0]    route_wr_sel = '0;
    logic [4:0]    route_wr_val = '0;
    logic [NT*32-1:0] route_cap = '1;
    logic [1:0]    route_rd_sel = '0;
    logic [4:0]    route_rd;
    logic [NT-1:0] msg_en = '0;
    logic [NT-1:0] msg_cap = '0;
    logic [31:0]   ioc_line;
    logic          leg_irq0;
    logic          leg_irq8;
    logic [NT-1:0] msg_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int exp_route [NT];
    logic [NT-1:0] prev_irq = '0;

    always #4 clk = ~clk;

    timer_irq_router #(.NUM_TIMERS(NT)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .tmr_irq_i      (tmr_irq),
        .legacy_en_i    (legacy_en),
        .route_wr_i     (route_wr),
        .route_wr_sel_i (route_wr_sel),
        .route_wr_val_i (route_wr_val),
        .route_cap_i    (route_cap),
        .route_rd_sel_i (route_rd_sel),
        .route_rd_o     (route_rd),
        .msg_en_i       (msg_en),
        .msg_cap_i      (msg_cap),
        .ioc_line_o     (ioc_line),
        .leg_irq0_o     (leg_irq0),
        .leg_irq8_o     (leg_irq8),
        .msg_req_o      (msg_req)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit on_msg(int t);
        if (legacy_en && t < 2) return 1'b0;
        return msg_en[t] && msg_cap[t];
    endfunction

    function automatic logic [31:0] model_ioc(logic [NT-1:0] irq);
        logic [31:0] v = '0;
        for (int t = 0; t < NT; t++) begin
            if (irq[t]) begin
                if (legacy_en && t == 0)      v[2] = 1'b1;
                else if (legacy_en && t == 1) v[8] = 1'b1;
                else if (!on_msg(t))          v[exp_route[t]] = 1'b1;
            end
        end
        return v;
    endfunction

    task automatic apply(logic [NT-1:0] irq, string req);
        logic [NT-1:0] exp_req;
        @(negedge clk);
        tmr_irq = irq;
        @(posedge clk);
        @(negedge clk);
        exp_req = '0;
        for (int t = 0; t < NT; t++)
            exp_req[t] = on_msg(t) && irq[t] && !prev_irq[t];
        check(req, "ioc_line", ioc_line, model_ioc(irq));
        check(req, "leg_irq0", 32'(leg_irq0), 32'(legacy_en && irq[0]));
        check(req, "leg_irq8", 32'(leg_irq8), 32'(legacy_en && irq[1]));
        check(req, "msg_req", 32'(msg_req), 32'(exp_req));
        prev_irq = irq;
    endtask

    task automatic write_route(int t, int v);
        @(negedge clk);
        route_wr = 1'b1;
        route_wr_sel = 2'(t);
        route_wr_val = 5'(v);
        @(posedge clk);
        @(negedge clk);
        route_wr = 1'b0;
        if (route_cap[t*32 + v]) exp_route[t] = v;
    endtask

    task automatic read_check(int t, string req);
        route_rd_sel = 2'(t);
        #1;
        check(req, "route_rd", 32'(route_rd), 32'(exp_route[t]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) exp_route[t] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1", "ioc_line", ioc_line, 32'h0);
        check("R1", "legacy", {30'h0, leg_irq8, leg_irq0}, 32'h0);
        check("R1", "msg_req", 32'(msg_req), 32'h0);
        for (int t = 0; t < NT; t++) read_check(t, "R1");

        // R4/R5: every route of every timer with full capability
        for (int t = 0; t < NT; t++) begin
            for (int v = 0; v < 32; v++) begin
                write_route(t, v);
                read_check(t, "R5");
                apply(NT'(1 << t), "R4");
                apply('0, "R4");
            end
        end

        // R6: sparse capability masks reject some writes
        for (int t = 0; t < NT; t++)
            route_cap[t*32 +: 32] = 32'h9E37_79B9 ^ (32'h0F0F_0000 << t);
        for (int t = 0; t < NT; t++) begin
            for (int v = 0; v < 32; v++) begin
                write_route(t, v);
                read_check(t, route_cap[t*32 + v] ? "R5" : "R6");
                apply(NT'(1 << t), route_cap[t*32 + v] ? "R4" : "R6");
                apply('0, "R4");
            end
        end
        route_cap = '1;

        // R7: all timers on one input, then pairs sharing
        for (int t = 0; t < NT; t++) write_route(t, 13);
        for (int p = 0; p < 16; p++) apply(NT'(p), "R7");
        write_route(0, 20); write_route(1, 20); write_route(2, 3); write_route(3, 3);
        for (int p = 0; p < 16; p++) apply(NT'(p), "R7");

        // R2/R3: legacy replacement pins timers 0 and 1
        write_route(0, 5); write_route(1, 9); write_route(2, 13); write_route(3, 2);
        legacy_en = 1'b1;
        for (int p = 0; p < 16; p++) begin
            apply(NT'(p), p[1] ? "R3" : "R2");
            apply('0, "R2");
        end
        legacy_en = 1'b0;

        // R8/R9: message path across enable, capability and legacy settings
        for (int l = 0; l < 2; l++) begin
            for (int e = 0; e < 16; e++) begin
                for (int c = 0; c < 16; c++) begin
                    legacy_en = l[0];
                    msg_en = NT'(e);
                    msg_cap = NT'(c);
                    apply('1, (e & ~c) != 0 ? "R9" : "R8");
                    apply('1, "R8");
                    apply(NT'(5), "R8");
                    apply('0, "R9");
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule